// File: doc/BRIEF.md
# ASID-Tagged Translation Buffer With Selective Invalidation

This block caches translations for a 32-bit I/O virtual address space with 4 KiB pages. It is fully associative. Each entry holds a 7-bit address-space identifier (ASID), a 20-bit virtual page number, a 20-bit physical frame number and three permission bits. A client presents an ASID and a virtual page. One cycle after the lookup is accepted, the block answers with hit, frame and permissions. A miss marks a refill as outstanding. The external table walker then installs the translation through the refill port, and that refill ends the outstanding state.

Invalidation arrives as a single-cycle strobe carrying a 32-bit command word. The command selects one of three address scopes: everything, one 4 MiB section, or one 16 KiB group. Any of these scopes can also be narrowed to a single ASID. A configuration word sets three things: how many lines are in use, whether victims are chosen round-robin or by lowest free line, and whether hits may be served while a refill is outstanding.

Top module: `iotlb_asid`

## Requirements
- R1: An accepted lookup gives `rsp_valid_o`=1 one cycle later. If a valid entry has the same ASID and the same virtual page, `rsp_hit_o`=1 and `rsp_pfn_o`/`rsp_perm_o` show that entry's frame and permissions. Otherwise `rsp_hit_o`=0.
- R2: An accepted lookup that misses while no refill is outstanding raises `walk_pending_o` on the next cycle. It stays high until a cycle with `fill_valid_i`=1.
- R3: A refill writes its ASID, page, frame and permissions into the chosen victim line, and later lookups of that tag hit.
- R4: A command with bits [1:0]=0 and bit 31=0 invalidates every line.
- R5: With bit 31=1, only lines whose ASID equals command bits [30:24] are invalidated, within the selected address scope.
- R6: Bits [1:0]=2 invalidate lines whose page bits [19:10] (address bits [31:22]) equal command bits [19:10].
- R7: Bits [1:0]=3 invalidate lines whose page bits [19:2] (address bits [31:14]) equal command bits [19:2].
- R8: A command with bits [1:0]=1 changes nothing.
- R9: If an invalidation and a refill that it matches happen in the same cycle, the refilled line ends up invalid.
- R10: Configuration bits [5:0] set the active line count, and values above the entry count clamp to it. Only lines below the count can hit or be allocated. Writing a smaller count invalidates the lines above it. A count of 0 drops refills.
- R11: With configuration bit 28=1, victims rotate round-robin over the active lines. With bit 28=0, the victim is the lowest invalid active line, or line 0 if there is none. Any configuration write restarts the rotation at line 0.
- R12: With configuration bit 29=0, `lkp_ready_o` is low while a refill is outstanding, and stalled lookups get no answer. With bit 29=1, lookups are accepted and answered while a refill is outstanding.
- R13: After reset all lines are invalid, no refill is outstanding, `rsp_valid_o`=0, and the configuration is: bit 29 clear, bit 28 set, count equal to the entry count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration word |
| flush_we_i | input | 1 | Invalidation command strobe |
| flush_cmd_i | input | 32 | Invalidation command word |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_ready_o | output | 1 | Lookup can be accepted |
| lkp_asid_i | input | 7 | Lookup ASID |
| lkp_vpn_i | input | 20 | Lookup virtual page (address bits [31:12]) |
| rsp_valid_o | output | 1 | Lookup answer valid |
| rsp_hit_o | output | 1 | Lookup hit |
| rsp_pfn_o | output | 20 | Physical frame on hit |
| rsp_perm_o | output | 3 | Permission bits on hit |
| walk_pending_o | output | 1 | Refill outstanding |
| fill_valid_i | input | 1 | Refill strobe |
| fill_asid_i | input | 7 | Refill ASID |
| fill_vpn_i | input | 20 | Refill virtual page |
| fill_pfn_i | input | 20 | Refill physical frame |
| fill_perm_i | input | 3 | Refill permissions |

## Verification
The single-hit assertion assumes that the walker never installs a tag that is already valid. The stimulus respects this: it refills only tags that have missed, been invalidated, or never been used. The entry count is assumed to be at most 63, so the 6-bit count field can address every line. The assertions also assume that strobes are single-cycle pulses sampled at the clock edge. The bench drives every input on the falling edge and holds it for exactly one cycle.

// File: rtl/iotlb_pkg.sv
package iotlb_pkg;
  localparam int ASID_W      = 7;
  localparam int VPN_W       = 20;
  localparam int PFN_W       = 20;
  localparam int PERM_W      = 3;
  localparam int CMD_W       = 32;
  localparam int SEC_LO      = 10;  // page bit holding address bit 22
  localparam int GRP_LO      = 2;   // page bit holding address bit 14
  localparam int CMD_ASID_LO = 24;
  localparam int CMD_ASID_EN = 31;
  localparam int CFG_HUM_BIT = 29;
  localparam int CFG_RR_BIT  = 28;
  localparam int CFG_CNT_W   = 6;

  typedef enum logic [1:0] {
    FL_ALL     = 2'd0,
    FL_RSVD    = 2'd1,
    FL_SECTION = 2'd2,
    FL_GROUP   = 2'd3
  } flush_mode_e;

  typedef struct packed {
    logic                    valid;
    logic                    asid_en;
    logic [ASID_W-1:0]       asid;
    flush_mode_e             mode;
    logic [VPN_W-1:GRP_LO]   vpn_hi;
  } flush_req_t;

  typedef struct packed {
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [PFN_W-1:0]  pfn;
    logic [PERM_W-1:0] perm;
  } tlb_entry_t;

  function automatic logic flush_hits(flush_req_t r, logic [ASID_W-1:0] asid,
                                      logic [VPN_W-1:GRP_LO] vpn_hi);
    logic addr_ok;
    case (r.mode)
      FL_ALL:     addr_ok = 1'b1;
      FL_SECTION: addr_ok = (vpn_hi[VPN_W-1:SEC_LO] == r.vpn_hi[VPN_W-1:SEC_LO]);
      FL_GROUP:   addr_ok = (vpn_hi == r.vpn_hi);
      default:    addr_ok = 1'b0;
    endcase
    return r.valid && addr_ok && (!r.asid_en || (r.asid == asid));
  endfunction
endpackage

// File: rtl/iotlb_flush_dec.sv
module iotlb_flush_dec
  import iotlb_pkg::*;
(
  input  logic             flush_we_i,
  input  logic [CMD_W-1:0] cmd_i,
  output flush_req_t       req_o
);
  flush_mode_e mode;
  logic        unused_cmd;

  assign mode       = flush_mode_e'(cmd_i[1:0]);
  assign unused_cmd = ^cmd_i[CMD_ASID_LO-1:VPN_W];

  always_comb begin
    req_o.valid   = flush_we_i && (mode != FL_RSVD);
    req_o.asid_en = cmd_i[CMD_ASID_EN];
    req_o.asid    = cmd_i[CMD_ASID_LO +: ASID_W];
    req_o.mode    = mode;
    // page bits sit at the same positions in the command word
    req_o.vpn_hi  = cmd_i[VPN_W-1:GRP_LO];
  end
endmodule

// File: rtl/iotlb_entries.sv
module iotlb_entries
  import iotlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  cnt_next_i,
  input  logic [ASID_W-1:0] lkp_asid_i,
  input  logic [VPN_W-1:0]  lkp_vpn_i,
  output logic              hit_o,
  output logic [PFN_W-1:0]  pfn_o,
  output logic [PERM_W-1:0] perm_o,
  output logic [ENTRIES-1:0] valid_o,
  input  logic              fill_en_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  tlb_entry_t        fill_i,
  input  flush_req_t        flush_i
);
  logic [ENTRIES-1:0] hit_vec;
  tlb_entry_t         ents [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_line
    tlb_entry_t e_q, e_wr;
    logic       v_q, here, kill;

    assign here = fill_en_i && (fill_idx_i == IDX_W'(i));
    assign e_wr = here ? fill_i : e_q;
    // an invalidation in the same cycle applies to the refilled tag
    assign kill = flush_hits(flush_i, e_wr.asid, e_wr.vpn[VPN_W-1:GRP_LO]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        e_q <= '0;
      end else begin
        v_q <= (v_q || here) && !kill && (CNT_W'(i) < cnt_next_i);
        e_q <= e_wr;
      end
    end

    assign valid_o[i] = v_q;
    assign ents[i]    = e_q;
    assign hit_vec[i] = v_q && (e_q.asid == lkp_asid_i) && (e_q.vpn == lkp_vpn_i);

    p_inactive_invalid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      v_q |-> (CNT_W'(i) < cnt_i));
  end

  always_comb begin
    pfn_o  = '0;
    perm_o = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      if (hit_vec[k]) begin
        pfn_o  = pfn_o | ents[k].pfn;
        perm_o = perm_o | ents[k].perm;
      end
    end
  end
  assign hit_o = |hit_vec;

  p_single_hit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));

  p_flush_all_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i.valid && flush_i.mode == FL_ALL && !flush_i.asid_en) |=> (valid_o == '0));
endmodule

// File: rtl/iotlb_victim.sv
module iotlb_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rr_en_i,
  input  logic               restart_i,
  input  logic               fill_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [ENTRIES-1:0] valid_i,
  output logic [IDX_W-1:0]   victim_o
);
  logic [IDX_W-1:0] ptr_q, ptr_eff, first_free;

  assign ptr_eff = (CNT_W'(ptr_q) >= cnt_i) ? '0 : ptr_q;

  always_comb begin
    first_free = '0;
    for (int k = ENTRIES - 1; k >= 0; k--) begin
      if ((CNT_W'(k) < cnt_i) && !valid_i[k]) first_free = IDX_W'(k);
    end
  end

  assign victim_o = rr_en_i ? ptr_eff : first_free;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (restart_i) begin
      ptr_q <= '0;
    end else if (fill_i && rr_en_i) begin
      ptr_q <= ((CNT_W'(ptr_eff) + CNT_W'(1)) >= cnt_i) ? '0 : ptr_eff + IDX_W'(1);
    end
  end

  p_victim_active_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |-> (CNT_W'(victim_o) < cnt_i));
endmodule

// File: rtl/iotlb_asid.sv
module iotlb_asid
  import iotlb_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              flush_we_i,
  input  logic [31:0]       flush_cmd_i,
  input  logic              lkp_valid_i,
  output logic              lkp_ready_o,
  input  logic [6:0]        lkp_asid_i,
  input  logic [19:0]       lkp_vpn_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [19:0]       rsp_pfn_o,
  output logic [2:0]        rsp_perm_o,
  output logic              walk_pending_o,
  input  logic              fill_valid_i,
  input  logic [6:0]        fill_asid_i,
  input  logic [19:0]       fill_vpn_i,
  input  logic [19:0]       fill_pfn_i,
  input  logic [2:0]        fill_perm_i
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int CNT_W = $clog2(ENTRIES + 1);

  logic                 hum_q, rr_q, pending_q, acc, fill_en, hit;
  logic [CNT_W-1:0]     cnt_q, cnt_wr, cnt_next;
  logic [CFG_CNT_W-1:0] cnt_raw;
  logic [IDX_W-1:0]     victim;
  logic [PFN_W-1:0]     hit_pfn;
  logic [PERM_W-1:0]    hit_perm;
  logic [ENTRIES-1:0]   valid_vec;
  logic                 rsp_valid_q, rsp_hit_q;
  logic [PFN_W-1:0]     rsp_pfn_q;
  logic [PERM_W-1:0]    rsp_perm_q;
  flush_req_t           flush_req;
  tlb_entry_t           fill_ent;
  logic                 unused_cfg;

  assign unused_cfg = ^{cfg_wdata_i[31:CFG_HUM_BIT+1], cfg_wdata_i[CFG_RR_BIT-1:CFG_CNT_W]};
  assign cnt_raw    = cfg_wdata_i[CFG_CNT_W-1:0];
  assign cnt_wr     = (cnt_raw > CFG_CNT_W'(ENTRIES)) ? CNT_W'(ENTRIES) : CNT_W'(cnt_raw);
  assign cnt_next   = cfg_we_i ? cnt_wr : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hum_q <= 1'b0;
      rr_q  <= 1'b1;
      cnt_q <= CNT_W'(ENTRIES);
    end else if (cfg_we_i) begin
      hum_q <= cfg_wdata_i[CFG_HUM_BIT];
      rr_q  <= cfg_wdata_i[CFG_RR_BIT];
      cnt_q <= cnt_wr;
    end
  end

  assign lkp_ready_o = !pending_q || hum_q;
  assign acc         = lkp_valid_i && lkp_ready_o;
  assign fill_en     = fill_valid_i && (cnt_q != '0);
  assign fill_ent    = '{asid: fill_asid_i, vpn: fill_vpn_i, pfn: fill_pfn_i, perm: fill_perm_i};

  iotlb_flush_dec u_dec (
    .flush_we_i (flush_we_i),
    .cmd_i      (flush_cmd_i),
    .req_o      (flush_req)
  );

  iotlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rr_en_i   (rr_q),
    .restart_i (cfg_we_i),
    .fill_i    (fill_en),
    .cnt_i     (cnt_q),
    .valid_i   (valid_vec),
    .victim_o  (victim)
  );

  iotlb_entries #(.ENTRIES(ENTRIES)) u_ents (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_i      (cnt_q),
    .cnt_next_i (cnt_next),
    .lkp_asid_i (lkp_asid_i),
    .lkp_vpn_i  (lkp_vpn_i),
    .hit_o      (hit),
    .pfn_o      (hit_pfn),
    .perm_o     (hit_perm),
    .valid_o    (valid_vec),
    .fill_en_i  (fill_en),
    .fill_idx_i (victim),
    .fill_i     (fill_ent),
    .flush_i    (flush_req)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_pfn_q   <= '0;
      rsp_perm_q  <= '0;
      pending_q   <= 1'b0;
    end else begin
      rsp_valid_q <= acc;
      if (acc) begin
        rsp_hit_q  <= hit;
        rsp_pfn_q  <= hit ? hit_pfn : '0;
        rsp_perm_q <= hit ? hit_perm : '0;
      end
      // a miss under an outstanding refill does not open a second one
      pending_q <= (pending_q && !fill_valid_i) || (acc && !hit && !pending_q);
    end
  end

  assign rsp_valid_o    = rsp_valid_q;
  assign rsp_hit_o      = rsp_hit_q;
  assign rsp_pfn_o      = rsp_pfn_q;
  assign rsp_perm_o     = rsp_perm_q;
  assign walk_pending_o = pending_q;

  p_rsp_after_accept_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_valid_i && lkp_ready_o) |=> rsp_valid_o);

  p_pending_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (walk_pending_o && !fill_valid_i) |=> walk_pending_o);

  p_fill_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (walk_pending_o && fill_valid_i) |=> !walk_pending_o);
endmodule

// File: tb/iotlb_asid_tb_top.sv
`timescale 1ns/1ps
module iotlb_asid_tb_top;
  localparam real CLK_NS = 8.0;
  localparam int  NVEC   = 28;
  // {req[3:0], op[1:0], asid[6:0], vpn[19:0], data[31:0]}
  // op 0 refill (data[22:20] perm, data[19:0] frame), 1 lookup (data[31] hit,
  // data[22:20] perm, data[19:0] frame), 2 invalidation (data = command)
  localparam logic [64:0] VEC [NVEC] = '{
    {4'd3, 2'd0, 7'd1, 20'h00401, 32'h0071_1111},
    {4'd3, 2'd0, 7'd2, 20'h00401, 32'h0052_2222},
    {4'd3, 2'd0, 7'd1, 20'h00800, 32'h0033_3333},
    {4'd3, 2'd0, 7'd3, 20'h00C04, 32'h0014_4444},
    {4'd3, 2'd0, 7'd3, 20'h00C08, 32'h0025_5555},
    {4'd1, 2'd1, 7'd1, 20'h00401, 32'h8071_1111}, // R1
    {4'd1, 2'd1, 7'd2, 20'h00401, 32'h8052_2222}, // R1 asid selects
    {4'd1, 2'd1, 7'd3, 20'h00401, 32'h0000_0000}, // R1 asid mismatch
    {4'd1, 2'd1, 7'd1, 20'h00402, 32'h0000_0000}, // R1 page mismatch
    {4'd3, 2'd1, 7'd3, 20'h00C08, 32'h8025_5555}, // R3
    {4'd8, 2'd2, 7'd0, 20'h0,     32'h0000_0001}, // R8 reserved mode
    {4'd8, 2'd1, 7'd1, 20'h00401, 32'h8071_1111},
    {4'd8, 2'd1, 7'd1, 20'h00800, 32'h8033_3333},
    {4'd5, 2'd2, 7'd0, 20'h0,     32'h8200_0000}, // R5 asid 2, all
    {4'd5, 2'd1, 7'd2, 20'h00401, 32'h0000_0000},
    {4'd5, 2'd1, 7'd1, 20'h00401, 32'h8071_1111},
    {4'd6, 2'd2, 7'd0, 20'h0,     32'h0000_0802}, // R6 section 0x002
    {4'd6, 2'd1, 7'd1, 20'h00800, 32'h0000_0000},
    {4'd6, 2'd1, 7'd1, 20'h00401, 32'h8071_1111},
    {4'd6, 2'd1, 7'd3, 20'h00C04, 32'h8014_4444},
    {4'd7, 2'd2, 7'd0, 20'h0,     32'h8400_0C07}, // R7 group, wrong asid
    {4'd7, 2'd1, 7'd3, 20'h00C04, 32'h8014_4444},
    {4'd7, 2'd2, 7'd0, 20'h0,     32'h8300_0C07}, // R7 group, asid 3
    {4'd7, 2'd1, 7'd3, 20'h00C04, 32'h0000_0000},
    {4'd7, 2'd1, 7'd3, 20'h00C08, 32'h8025_5555}, // neighbour group kept
    {4'd4, 2'd2, 7'd0, 20'h0,     32'h0000_0000}, // R4 everything
    {4'd4, 2'd1, 7'd1, 20'h00401, 32'h0000_0000},
    {4'd4, 2'd1, 7'd3, 20'h00C08, 32'h0000_0000}
  };

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        cfg_we_i = 0, flush_we_i = 0, lkp_valid_i = 0, fill_valid_i = 0;
  logic [31:0] cfg_wdata_i = 0, flush_cmd_i = 0;
  logic [6:0]  lkp_asid_i = 0, fill_asid_i = 0;
  logic [19:0] lkp_vpn_i = 0, fill_vpn_i = 0, fill_pfn_i = 0;
  logic [2:0]  fill_perm_i = 0;
  logic        lkp_ready_o, rsp_valid_o, rsp_hit_o, walk_pending_o;
  logic [19:0] rsp_pfn_o;
  logic [2:0]  rsp_perm_o;
  int          n_chk = 0, n_fail = 0;

  always #(CLK_NS/2) clk_i = ~clk_i;

  iotlb_asid dut_i (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg(logic [31:0] w);
    cfg_we_i = 1; cfg_wdata_i = w;
    @(negedge clk_i);
    cfg_we_i = 0;
  endtask

  task automatic flush(logic [31:0] c);
    flush_we_i = 1; flush_cmd_i = c;
    @(negedge clk_i);
    flush_we_i = 0;
  endtask

  task automatic fill(logic [6:0] a, logic [19:0] v, logic [19:0] p, logic [2:0] pm);
    fill_valid_i = 1; fill_asid_i = a; fill_vpn_i = v; fill_pfn_i = p; fill_perm_i = pm;
    @(negedge clk_i);
    fill_valid_i = 0;
  endtask

  task automatic lookup(string req, logic [6:0] a, logic [19:0] v, logic [31:0] exp);
    logic [31:0] act;
    lkp_valid_i = 1; lkp_asid_i = a; lkp_vpn_i = v;
    @(negedge clk_i);
    lkp_valid_i = 0;
    act = !rsp_valid_o ? 32'h0BAD_0000 :
          (rsp_hit_o ? {1'b1, 8'h0, rsp_perm_o, rsp_pfn_o} : 32'h0);
    check(req, act, exp);
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R13 reset state
    check("R13 ready", 32'(lkp_ready_o), 32'd1);
    check("R13 pending", 32'(walk_pending_o), 32'd0);
    check("R13 rsp_valid", 32'(rsp_valid_o), 32'd0);

    // R12 default: no hit-under-miss, so a miss stalls further lookups
    lookup("R2 miss", 7'd5, 20'h12345, 32'h0);
    check("R2 pending set", 32'(walk_pending_o), 32'd1);
    check("R12 stall ready", 32'(lkp_ready_o), 32'd0);
    lkp_valid_i = 1;
    @(negedge clk_i);
    lkp_valid_i = 0;
    check("R12 stalled no answer", 32'(rsp_valid_o), 32'd0);
    fill(7'd5, 20'h12345, 20'hABCDE, 3'd6);
    check("R2 pending cleared", 32'(walk_pending_o), 32'd0);
    check("R12 ready again", 32'(lkp_ready_o), 32'd1);
    lookup("R3 refill hit", 7'd5, 20'h12345, 32'h806A_BCDE);

    cfg(32'h3000_0008);
    for (int i = 0; i < NVEC; i++) begin
      logic [64:0] v;
      v = VEC[i];
      case (v[60:59])
        2'd0: fill(v[58:52], v[51:32], v[19:0], v[22:20]);
        2'd2: flush(v[31:0]);
        default: lookup($sformatf("R%0d vector %0d", v[64:61], i), v[58:52], v[51:32], v[31:0]);
      endcase
    end

    // R9 invalidation racing a refill
    fill_valid_i = 1; fill_asid_i = 7'd6; fill_vpn_i = 20'h00010;
    fill_pfn_i = 20'h01010; fill_perm_i = 3'd7;
    flush_we_i = 1; flush_cmd_i = 32'h8600_0000;
    @(negedge clk_i);
    fill_valid_i = 0; flush_we_i = 0;
    lookup("R9 racing kill", 7'd6, 20'h00010, 32'h0);
    fill_valid_i = 1; fill_asid_i = 7'd6; fill_vpn_i = 20'h00020;
    fill_pfn_i = 20'h02020; fill_perm_i = 3'd7;
    flush_we_i = 1; flush_cmd_i = 32'h8700_0000;
    @(negedge clk_i);
    fill_valid_i = 0; flush_we_i = 0;
    lookup("R9 unrelated kept", 7'd6, 20'h00020, 32'h8070_2020);

    // R10 active line count
    flush(32'h0);
    cfg(32'h3000_0002);
    fill(7'd1, 20'h10000, 20'h0000A, 3'd1);
    fill(7'd1, 20'h10001, 20'h0000B, 3'd1);
    fill(7'd1, 20'h10002, 20'h0000C, 3'd1);
    lookup("R10 two lines wrap", 7'd1, 20'h10000, 32'h0);
    lookup("R10 line1", 7'd1, 20'h10001, 32'h8010_000B);
    lookup("R10 line0", 7'd1, 20'h10002, 32'h8010_000C);
    cfg(32'h3000_0001);
    lookup("R10 shrink drops", 7'd1, 20'h10001, 32'h0);
    lookup("R10 shrink keeps", 7'd1, 20'h10002, 32'h8010_000C);
    cfg(32'h3000_0000);
    lookup("R10 zero no hit", 7'd1, 20'h10002, 32'h0);
    fill(7'd1, 20'h10003, 20'h0000D, 3'd1);
    lookup("R10 zero drops refill", 7'd1, 20'h10003, 32'h0);
    cfg(32'h3000_003F);
    fill(7'd1, 20'h10004, 20'h0000E, 3'd1);
    lookup("R10 clamp", 7'd1, 20'h10004, 32'h8010_000E);

    // R11 lowest-free replacement
    flush(32'h0);
    cfg(32'h2000_0004);
    fill(7'd1, 20'h20000, 20'h1, 3'd1);
    fill(7'd1, 20'h20004, 20'h2, 3'd1);
    fill(7'd1, 20'h20008, 20'h3, 3'd1);
    fill(7'd1, 20'h2000C, 20'h4, 3'd1);
    flush(32'h0002_0007);
    fill(7'd1, 20'h20010, 20'h5, 3'd1);
    lookup("R11 free line reused", 7'd1, 20'h20000, 32'h8010_0001);
    lookup("R11 new in free line", 7'd1, 20'h20010, 32'h8010_0005);
    fill(7'd1, 20'h20014, 20'h6, 3'd1);
    lookup("R11 full evicts line0", 7'd1, 20'h20000, 32'h0);
    lookup("R11 line2 kept", 7'd1, 20'h20008, 32'h8010_0003);

    // R11 round-robin replacement
    flush(32'h0);
    cfg(32'h3000_0004);
    fill(7'd1, 20'h30000, 20'h1, 3'd2);
    fill(7'd1, 20'h30004, 20'h2, 3'd2);
    fill(7'd1, 20'h30008, 20'h3, 3'd2);
    fill(7'd1, 20'h3000C, 20'h4, 3'd2);
    flush(32'h0003_0007);
    fill(7'd1, 20'h30010, 20'h5, 3'd2);
    lookup("R11 rr evicts line0", 7'd1, 20'h30000, 32'h0);
    lookup("R11 rr new hit", 7'd1, 20'h30010, 32'h8020_0005);
    lookup("R11 rr line2 kept", 7'd1, 20'h30008, 32'h8020_0003);

    // R12 hit under miss
    flush(32'h0);
    cfg(32'h3000_0008);
    fill(7'd1, 20'h40000, 20'h00004, 3'd2);
    lookup("R12 miss", 7'd1, 20'h40001, 32'h0);
    check("R12 pending", 32'(walk_pending_o), 32'd1);
    check("R12 ready under miss", 32'(lkp_ready_o), 32'd1);
    lookup("R12 hit under miss", 7'd1, 20'h40000, 32'h8020_0004);
    check("R2 still pending", 32'(walk_pending_o), 32'd1);
    fill(7'd1, 20'h40001, 20'h00005, 3'd2);
    check("R2 refill ends pending", 32'(walk_pending_o), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule